// File: doc/BRIEF.md
# Two-Wire Edge-Counting Shift Unit

This block is the low-level engine under a software-driven master on an open-drain two-wire bus. It holds one byte in a shift register and a 4-bit counter that advances on every SCL transition seen on the bus, rising and falling alike. Software starts a transfer by loading a counter preset and a data byte. It then produces each SCL half-period by writing the control register with the toggle bit set. It polls the overflow flag to learn that the transfer is over. A preset of 0 gives a byte (16 edges) and a preset of 14 gives a single bit (2 edges), which serves for acknowledge slots.

The line levels are sampled through a synchronizer. The same sampled view feeds the counter, the shift input and a set of bus-event flags: start seen, overflow, stop seen and collision. Each flag is cleared by writing a one to it. Both lines are open-drain: the block only ever pulls a line low or lets it go. A separate force-low bit and a level bit allow start, repeated start and stop conditions to be built by hand.

Top module: `tws_shift_unit`

## Requirements
- R1: After reset the data register reads 0xFF, the status register reads 0x00, the control register reads 0x00, and neither sclOe nor sdaOe pulls its line low.
- R2: A control write (address 2) with bit 0 set inverts the SCL hold-low state once, so two such writes form a full clock pulse. A control write with bit 0 clear sets the hold-low state from bit 1. Bit 1 of the control register reads back the hold-low state, and sclOe equals it.
- R3: The counter (status bits 3:0) increments by one on each rising and on each falling SCL transition on the bus. From a preset of 0, the overflow flag (status bit 6) stays clear after 15 transitions and is set, with the count back at 0, after the 16th.
- R4: From a preset of 14 the counter reads 15 with overflow clear after one transition, and reads 0 with overflow set after the second.
- R5: On each rising SCL transition the data register (address 0) shifts left by one, and the sampled SDA level enters bit 0. After 16 transitions it holds the eight bits that were on SDA at the rising edges, first bit in bit 7.
- R6: sdaOe is 1 only when SDA driving is enabled (control bit 3) and either the force-low bit (control bit 2) is set or the SDA output latch is 0. The latch follows data bit 7 while SCL is low and holds while SCL is high.
- R7: SDA falling while SCL is high sets the start flag (status bit 7).
- R8: SDA rising while SCL is high sets the stop flag (status bit 5).
- R9: At a rising SCL transition with SDA driving enabled and force-low clear, a released SDA latch combined with a low sampled SDA sets the collision flag (status bit 4).
- R10: A status write (address 1) clears each flag whose bit in bits 7:4 is 1 and leaves flags written with 0 unchanged. An event in the same cycle as a clear takes priority over the clear.
- R11: A status write loads the counter from bits 3:0, and a data write loads the data register; each load takes priority over a bus edge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register (combinational) |
| sclIn | input | 1 | Sampled SCL bus level |
| sdaIn | input | 1 | Sampled SDA bus level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |

## Verification
Several checks run on every cycle: SDA is never pulled low while driving is disabled, the counter steps by exactly one per bus edge, the shift register moves one place per rising edge, and the output latch stays still while SCL is high. Each detected start, stop or overflow event is also checked to appear in its flag on the next cycle. The values on the wire are shown only by the bench's scenarios. These cover a full byte driven out and read back from the bus, a byte received from a modelled target and an acknowledge slot. They also cover a forced collision, hand-built start and stop conditions, and selective write-one clearing of the flags.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int TWS_DATA_W = 8;
  localparam int TWS_CNT_W  = 4;
  localparam int TWS_ADDR_W = 2;

  localparam logic [TWS_ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [TWS_ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [TWS_ADDR_W-1:0] ADDR_CTRL = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 loadData;
    logic                 loadCount;
    logic [TWS_CNT_W-1:0] preset;
    logic [TWS_DATA_W-1:0] wrValue;
    logic                 countEdge;
    logic                 shiftIn;
    logic                 sdaBit;
    logic                 sclLow;
  } twsStrobe_t;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '1;
          else       chain[s] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '1;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  twsStrobe_t            strobe,
  output logic [TWS_DATA_W-1:0] dataReg,
  output logic [TWS_CNT_W-1:0]  count,
  output logic                  sdaLatch,
  output logic                  ovfPulse
);
  localparam logic [TWS_CNT_W-1:0] CNT_MAX = '1;

  assign ovfPulse = strobe.countEdge && !strobe.loadCount && (count == CNT_MAX);

  // shift register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dataReg <= '1;
    else if (strobe.loadData) dataReg <= strobe.wrValue;
    else if (strobe.shiftIn)  dataReg <= {dataReg[TWS_DATA_W-2:0], strobe.sdaBit};
  end

  // edge counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  count <= '0;
    else if (strobe.loadCount)  count <= strobe.preset;
    else if (strobe.countEdge)  count <= count + 1'b1;
  end

  // output latch: transparent while SCL low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sdaLatch <= 1'b1;
    else if (strobe.sclLow) sdaLatch <= dataReg[TWS_DATA_W-1];
  end

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEdge && !strobe.loadCount) |=> (count == $past(count) + 1'b1));

  p_shift_one_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftIn && !strobe.loadData) |=>
      (dataReg[TWS_DATA_W-1:1] == $past(dataReg[TWS_DATA_W-2:0])));

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.sclLow && !$past(strobe.sclLow)) |-> $stable(sdaLatch));
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [TWS_ADDR_W-1:0] addr,
  input  logic [TWS_DATA_W-1:0] wrData,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic                  ovfPulse,
  input  logic                  sdaLatch,
  output twsStrobe_t            strobe,
  output logic [3:0]            flags,
  output logic                  sclHoldLow,
  output logic                  sdaForceLow,
  output logic                  sdaOutEn
);
  logic [1:0] busSync;
  logic       sclS, sdaS, sclPrev, sdaPrev;
  logic       sclRise, sclEdge, startSeen, stopSeen, collSeen;
  logic       wrStat, wrCtrl, wrDataReg;
  logic       flagStart, flagOvf, flagStop, flagColl;

  tws_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({sclIn, sdaIn}),
    .dout (busSync)
  );
  assign sclS = busSync[1];
  assign sdaS = busSync[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise   = sclS && !sclPrev;
  assign sclEdge   = sclS ^ sclPrev;
  assign startSeen = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopSeen  = sclS && sclPrev && !sdaPrev && sdaS;
  assign collSeen  = sclRise && sdaOutEn && !sdaForceLow && sdaLatch && !sdaS;

  assign wrStat    = wrEn && (addr == ADDR_STAT);
  assign wrCtrl    = wrEn && (addr == ADDR_CTRL);
  assign wrDataReg = wrEn && (addr == ADDR_DATA);

  always_comb begin
    strobe.loadData  = wrDataReg;
    strobe.loadCount = wrStat;
    strobe.preset    = wrData[TWS_CNT_W-1:0];
    strobe.wrValue   = wrData;
    strobe.countEdge = sclEdge;
    strobe.shiftIn   = sclRise;
    strobe.sdaBit    = sdaS;
    strobe.sclLow    = !sclS;
  end

  // flags: event sets, write-one clears, event wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagStart <= 1'b0;
      flagOvf   <= 1'b0;
      flagStop  <= 1'b0;
      flagColl  <= 1'b0;
    end else begin
      flagStart <= startSeen || (flagStart && !(wrStat && wrData[7]));
      flagOvf   <= ovfPulse  || (flagOvf   && !(wrStat && wrData[6]));
      flagStop  <= stopSeen  || (flagStop  && !(wrStat && wrData[5]));
      flagColl  <= collSeen  || (flagColl  && !(wrStat && wrData[4]));
    end
  end
  assign flags = {flagStart, flagOvf, flagStop, flagColl};

  // control bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclHoldLow  <= 1'b0;
      sdaForceLow <= 1'b0;
      sdaOutEn    <= 1'b0;
    end else if (wrCtrl) begin
      sclHoldLow  <= wrData[0] ? !sclHoldLow : wrData[1];
      sdaForceLow <= wrData[2];
      sdaOutEn    <= wrData[3];
    end
  end

  p_start_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> flagStart);

  p_stop_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> flagStop);

  p_ovf_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> flagOvf);

  p_toggle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && wrData[0]) |=> (sclHoldLow != $past(sclHoldLow)));
endmodule

// File: rtl/tws_shift_unit.sv
module tws_shift_unit
  import tws_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [TWS_ADDR_W-1:0] addr,
  input  logic [TWS_DATA_W-1:0] wrData,
  output logic [TWS_DATA_W-1:0] rdData,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sclOe,
  output logic                  sdaOe
);
  twsStrobe_t            strobe;
  logic [TWS_DATA_W-1:0] dataReg;
  logic [TWS_CNT_W-1:0]  count;
  logic                  sdaLatch, ovfPulse;
  logic [3:0]            flags;
  logic                  sclHoldLow, sdaForceLow, sdaOutEn;

  tws_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .addr        (addr),
    .wrData      (wrData),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .ovfPulse    (ovfPulse),
    .sdaLatch    (sdaLatch),
    .strobe      (strobe),
    .flags       (flags),
    .sclHoldLow  (sclHoldLow),
    .sdaForceLow (sdaForceLow),
    .sdaOutEn    (sdaOutEn)
  );

  tws_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataReg  (dataReg),
    .count    (count),
    .sdaLatch (sdaLatch),
    .ovfPulse (ovfPulse)
  );

  assign sclOe = sclHoldLow;
  assign sdaOe = sdaOutEn && (sdaForceLow || !sdaLatch);

  always_comb begin
    case (addr)
      ADDR_DATA: rdData = dataReg;
      ADDR_STAT: rdData = {flags, count};
      ADDR_CTRL: rdData = {4'b0, sdaOutEn, sdaForceLow, sclHoldLow, 1'b0};
      default:   rdData = '0;
    endcase
  end

  p_sda_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !sdaOutEn |-> !sdaOe);
endmodule

// File: tb/tws_shift_unit_tb.sv
module tws_shift_unit_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       sclOe, sdaOe;
  logic       tgtSdaLow = 1'b0;
  logic       sclIn, sdaIn;
  int         total = 0;
  int         bad = 0;

  assign sclIn = !sclOe;
  assign sdaIn = !sdaOe && !tgtSdaLow;

  always #5 clk = ~clk;

  tws_shift_unit u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .sclIn(sclIn), .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic toggle(input logic [7:0] cfg);
    regWrite(2'd2, cfg | 8'h01);
    settle();
  endtask

  task automatic testReset();
    logic [7:0] v;
    regRead(2'd0, v); check("R1 data", v, 8'hFF);
    regRead(2'd1, v); check("R1 status", v, 8'h00);
    regRead(2'd2, v); check("R1 control", v, 8'h00);
    check("R1 lines", {6'd0, sclOe, sdaOe}, 8'h00);
  endtask

  task automatic testToggle();
    logic [7:0] v;
    toggle(8'h00);
    regRead(2'd2, v); check("R2 toggle low", v, 8'h02);
    check("R2 sclOe", {7'd0, sclOe}, 8'h01);
    toggle(8'h00);
    regRead(2'd2, v); check("R2 toggle back", v, 8'h00);
    regRead(2'd1, v); check("R3 two edges", v, 8'h02);
    regWrite(2'd2, 8'h02); settle();
    check("R2 level write", {7'd0, sclOe}, 8'h01);
    regRead(2'd1, v); check("R3 third edge", v, 8'h03);
  endtask

  task automatic testSendByte();
    logic [7:0] v;
    logic [7:0] pat = 8'hA5;
    regWrite(2'd2, 8'h0A);
    regWrite(2'd0, pat);
    regWrite(2'd1, 8'hF0);
    settle();
    for (int i = 7; i >= 0; i--) begin
      check("R6 sda drive", {7'd0, sdaOe}, {7'd0, !pat[i]});
      toggle(8'h08);
      if (i == 0) begin
        regRead(2'd1, v); check("R3 no ovf at 15", v, 8'h0F);
      end
      toggle(8'h08);
    end
    regRead(2'd1, v); check("R3 ovf at 16", v, 8'h40);
    regRead(2'd0, v); check("R5 loopback", v, pat);
  endtask

  task automatic testRecvByte();
    logic [7:0] v;
    logic [7:0] pat = 8'h3C;
    regWrite(2'd0, 8'hFF);
    regWrite(2'd2, 8'h02);
    regWrite(2'd1, 8'hF0);
    for (int i = 7; i >= 0; i--) begin
      tgtSdaLow = !pat[i];
      settle();
      toggle(8'h00);
      check("R6 no drive when disabled", {7'd0, sdaOe}, 8'h00);
      toggle(8'h00);
    end
    tgtSdaLow = 1'b0;
    settle();
    regRead(2'd0, v); check("R5 received", v, pat);
    regRead(2'd1, v); check("R3 recv ovf", v, 8'h40);
  endtask

  task automatic testAckBit();
    logic [7:0] v;
    regWrite(2'd0, 8'hFF);
    regWrite(2'd1, 8'hFE);
    tgtSdaLow = 1'b1;
    settle();
    toggle(8'h00);
    regRead(2'd1, v); check("R4 one edge", v, 8'h0F);
    toggle(8'h00);
    regRead(2'd1, v); check("R4 two edges", v, 8'h40);
    regRead(2'd0, v); check("R4 ack bit", v, 8'hFE);
    tgtSdaLow = 1'b0;
    settle();
  endtask

  task automatic testCollision();
    logic [7:0] v;
    regWrite(2'd1, 8'hF0);
    regWrite(2'd2, 8'h0A);
    regWrite(2'd0, 8'hFF);
    tgtSdaLow = 1'b1;
    settle();
    toggle(8'h08);
    regRead(2'd1, v); check("R9 collision", v & 8'hF0, 8'h10);
    toggle(8'h08);
    tgtSdaLow = 1'b0;
    settle();
    regWrite(2'd1, 8'h10);
    regRead(2'd1, v); check("R9 R11 cleared and preset", v, 8'h00);
  endtask

  task automatic testStartStop();
    logic [7:0] v;
    regWrite(2'd2, 8'h0A);
    regWrite(2'd0, 8'hFF);
    regWrite(2'd1, 8'hF0);
    settle();
    regWrite(2'd2, 8'h08); settle();
    regWrite(2'd2, 8'h0C); settle();
    check("R6 force low", {7'd0, sdaOe}, 8'h01);
    regRead(2'd1, v); check("R7 start", v & 8'hF0, 8'h80);
    regWrite(2'd2, 8'h08); settle();
    regRead(2'd1, v); check("R8 stop", v & 8'hF0, 8'hA0);
    regWrite(2'd1, 8'h81);
    regRead(2'd1, v); check("R10 selective clear", v, 8'h21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    testReset();
    testToggle();
    testSendByte();
    testRecvByte();
    testAckBit();
    testCollision();
    testStartStop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule